// File: doc/BRIEF.md
# Debug Scan Module Selector with CPU Control Register

This block sits at the top of a JTAG debug unit, clocked by the test clock. The TAP controller drives its capture, shift and update strobes, and it receives TDI and returns TDO. At every update-DR it decodes the scan that has just been shifted in. The bit that arrived last decides how the scan is read. A 1 marks a module-select command. In that case the two bits shifted just before it name one of four sub-modules, and that sub-module's enable line is raised. A 0 marks a command for the sub-module that is already active. Those enables are how such commands reach the other sub-modules.

The block also holds the internal register file of the CPU sub-module (module ID 1). It has a 2-bit control register at index 0 that drives the CPU stall and reset lines. It also has a 1-bit register-index pointer. A host reads the selected register by shifting a NOP command; the value is loaded at capture-DR and leaves on TDO low bit first. A host writes the register by shifting the data bits ahead of the command bits. The write takes effect at update-DR.

Top module: `dbgsel_top`

## Requirements
- R1: After a synchronous active-low reset, no module is selected: all four enables are 0 and the active-module output is 0. Stall and reset are both 0.
- R2: Each cycle with shift_en high (and capture_en low) moves tdi into the most significant bit of an 8-bit scan register and drops its bit 0. TDO always shows bit 0 of that register.
- R3: At update_en, if the last bit shifted in is 1, the two bits shifted just before it become the active module ID (the earlier of the two is the ID's low bit; 0 bus, 1 CPU0, 2 CPU1, 3 serial port). Exactly that module's enable bit, mod_en[ID], is then raised.
- R4: At update_en, if the last bit shifted in is 0, the active module and the enables do not change.
- R5: Opcode 4'hD (register select), shifted as one index bit, then the four opcode bits LSB first, then the 0 flag, loads the CPU register-index pointer. This happens only while module 1 is active.
- R6: Opcode 4'h9 (register write), shifted as data bit 0, data bit 1, an index bit, the four opcode bits, then the 0 flag, loads the 2-bit data into the control register at update_en. This happens only while module 1 is active and the pointer is 0. Bit 0 drives cpu_stall and bit 1 drives cpu_reset. The index bit inside the write command itself is not used.
- R7: A write has no effect on stall or reset in any of these cases: no module is selected, another module is active, the pointer is 1, or the opcode is not 4'h9.
- R8: At capture_en, the scan register is loaded with the selected register's value in its low bits and zeros above. The value is 0 when module 1 is not active or the pointer is 1. A NOP (opcode 4'h0) scan leaves the control register unchanged.
- R9: If capture_en and update_en are high in the same cycle, the captured value is the control register as it was before that update. If capture_en and shift_en are high together, the capture wins and the shift is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_en | input | 1 | Capture-DR strobe |
| shift_en | input | 1 | Shift-DR strobe |
| update_en | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (scan register bit 0) |
| active_mod | output | 2 | ID of the active sub-module |
| mod_en | output | 4 | One enable per sub-module, at most one high |
| cpu_stall | output | 1 | CPU stall request (control bit 0) |
| cpu_reset | output | 1 | CPU reset request (control bit 1) |

## Verification
Two functions can act in the same clock cycle: a control-register write taking effect at update, and a capture that reads the same register back. The bench shifts a write scan and then raises capture_en and update_en together. It then shifts out the captured word without a new capture and expects the old control value. A later normal read must show the new value. A second directed case raises capture_en with shift_en on a control value whose two bits differ, and judges from TDO which strobe took effect.

// File: rtl/dbgsel_pkg.sv
// Shared constants, opcodes and the decoded-command type for the debug
// module selector. Assumes a fixed command layout of flag+opcode+index+data.
package dbgsel_pkg;
    localparam int ID_W   = 2;
    localparam int NUM_MOD = 1 << ID_W;
    localparam int OP_W   = 4;
    localparam int IDX_W  = 1;
    localparam int CTRL_W = 2;
    localparam int SR_W   = 1 + OP_W + IDX_W + CTRL_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 4'h0,
        OP_REG_WR  = 4'h9,
        OP_REG_SEL = 4'hD
    } op_e;

    typedef struct packed {
        logic              is_sel;
        logic [ID_W-1:0]   mod_id;
        logic [OP_W-1:0]   op;
        logic [IDX_W-1:0]  idx;
        logic [CTRL_W-1:0] wdata;
    } cmd_t;
endpackage

// File: rtl/dbgsel_shifter.sv
// Scan register: parallel load at capture, right shift with tdi entering at
// the MSB. Assumes the TAP never needs both loads; capture has priority.
module dbgsel_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_en,
    input  logic         shift_en,
    input  logic         tdi,
    input  logic [W-1:0] cap_val,
    output logic [W-1:0] sr_q,
    output logic         tdo
);
    // Load or shift the scan register.
    always_ff @(posedge clk) begin
        if (!rst_n)          sr_q <= '0;
        else if (capture_en) sr_q <= cap_val;
        else if (shift_en)   sr_q <= {tdi, sr_q[W-1:1]};
    end

    // Serial output is always the low bit.
    assign tdo = sr_q[0];
endmodule

// File: rtl/dbgsel_decoder.sv
// Splits the scan register into command fields, counted down from the MSB
// (the last bit shifted). Assumes W matches the package layout.
module dbgsel_decoder
    import dbgsel_pkg::*;
#(
    parameter int W = SR_W
) (
    input  logic [W-1:0] sr,
    output cmd_t         cmd
);
    localparam int OP_HI  = W - 2;
    localparam int IDX_HI = OP_HI - OP_W;
    localparam int DAT_HI = IDX_HI - IDX_W;

    // Pure field extraction, no state.
    always_comb begin
        cmd.is_sel = sr[W-1];
        cmd.mod_id = sr[OP_HI -: ID_W];
        cmd.op     = sr[OP_HI -: OP_W];
        cmd.idx    = sr[IDX_HI -: IDX_W];
        cmd.wdata  = sr[DAT_HI -: CTRL_W];
    end
endmodule

// File: rtl/dbgsel_cpuctl.sv
// CPU sub-module register file: a register-index pointer and the control
// register (bit0 stall, bit1 reset). Acts only on strobes the top has
// already qualified as addressed to this sub-module.
module dbgsel_cpuctl
    import dbgsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic [OP_W-1:0]   op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CTRL_W-1:0] rd_val
);
    logic [IDX_W-1:0] ptr_q;

    // Register-select opcode moves the index pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ptr_q <= '0;
        else if (cmd_stb && op == OP_REG_SEL)  ptr_q <= idx;
    end

    // Register-write opcode updates the control register at index 0 only.
    always_ff @(posedge clk) begin
        if (!rst_n)                                           ctrl_q <= '0;
        else if (cmd_stb && op == OP_REG_WR && ptr_q == '0)   ctrl_q <= wdata;
    end

    // Read path: only index 0 exists, other indices read as zero.
    assign rd_val = (ptr_q == '0) ? ctrl_q : '0;
endmodule

// File: rtl/dbgsel_top.sv
// Top level of the debug unit: decodes each update-DR as module select or
// sub-module command, drives per-module enables and the CPU control lines.
// Assumes the TAP delivers capture/shift/update as single-cycle strobes.
module dbgsel_top
    import dbgsel_pkg::*;
#(
    parameter int CPU_ID = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              tdi,
    output logic              tdo,
    output logic [ID_W-1:0]   active_mod,
    output logic [NUM_MOD-1:0] mod_en,
    output logic              cpu_stall,
    output logic              cpu_reset
);
    logic [SR_W-1:0]   sr_q;
    logic [SR_W-1:0]   cap_val;
    cmd_t              cmd;
    logic              valid_q;
    logic [ID_W-1:0]   active_q;
    logic              cpu_stb;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CTRL_W-1:0] rd_val;
    logic              cpu_active;

    dbgsel_shifter #(.W(SR_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .tdi(tdi), .cap_val(cap_val), .sr_q(sr_q), .tdo(tdo)
    );

    dbgsel_decoder #(.W(SR_W)) u_dec (.sr(sr_q), .cmd(cmd));

    // Latch the active module on a select command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            active_q <= '0;
        end else if (update_en && cmd.is_sel) begin
            valid_q  <= 1'b1;
            active_q <= cmd.mod_id;
        end
    end

    // CPU sub-module is addressed when it is the selected module.
    assign cpu_active = valid_q && (active_q == ID_W'(CPU_ID));
    assign cpu_stb    = update_en && !cmd.is_sel && cpu_active;

    dbgsel_cpuctl u_cpu (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cpu_stb), .op(cmd.op),
        .idx(cmd.idx), .wdata(cmd.wdata), .ctrl_q(ctrl_q), .rd_val(rd_val)
    );

    // Capture source: CPU register value in the low bits, zero otherwise.
    assign cap_val = cpu_active ? {{(SR_W-CTRL_W){1'b0}}, rd_val} : '0;

    // One enable per sub-module.
    for (genvar g = 0; g < NUM_MOD; g++) begin : g_en
        assign mod_en[g] = valid_q && (active_q == ID_W'(g));
    end

    assign active_mod = active_q;
    assign cpu_stall  = ctrl_q[0];
    assign cpu_reset  = ctrl_q[1];
endmodule

// File: rtl/dbgsel_chk.sv
// Property checker for dbgsel_top, attached by bind below.
module dbgsel_chk #(
    parameter int CPU_ID = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       capture_en,
    input logic       shift_en,
    input logic       update_en,
    input logic       tdo,
    input logic [1:0] active_mod,
    input logic [3:0] mod_en,
    input logic       cpu_stall,
    input logic       cpu_reset,
    input logic       sr_msb,
    input logic [1:0] sr_id,
    input logic       sr_next
);
    p_shift_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture_en) |=> tdo == $past(sr_next));

    p_onehot_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_en));

    p_sel_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (update_en && sr_msb) |=> (mod_en == (4'b0001 << $past(sr_id))) && (active_mod == $past(sr_id)));

    p_sel_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(update_en && sr_msb) |=> $stable(active_mod) && $stable(mod_en));

    p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !update_en |=> $stable(cpu_stall) && $stable(cpu_reset));

    p_other_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (update_en && !mod_en[CPU_ID]) |=> $stable(cpu_stall) && $stable(cpu_reset));

    p_cap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && !mod_en[CPU_ID] && !update_en) |=> !tdo);
endmodule

bind dbgsel_top dbgsel_chk #(.CPU_ID(CPU_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .tdo(tdo), .active_mod(active_mod), .mod_en(mod_en),
    .cpu_stall(cpu_stall), .cpu_reset(cpu_reset),
    .sr_msb(sr_q[dbgsel_pkg::SR_W-1]), .sr_id(sr_q[dbgsel_pkg::SR_W-2 -: 2]),
    .sr_next(sr_q[1])
);

// File: tb/dbgsel_top_tb.sv
`timescale 1ns/1ps
module dbgsel_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
    logic       tdo;
    logic [1:0] active_mod;
    logic [3:0] mod_en;
    logic       cpu_stall, cpu_reset;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Bench model of the block's visible state.
    bit       m_valid = 0;
    bit [1:0] m_act = 0;
    bit       m_idx = 0;
    bit [1:0] m_ctrl = 0;

    always #2.5 clk = ~clk;

    dbgsel_top u_dut (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .tdi(tdi), .tdo(tdo), .active_mod(active_mod),
        .mod_en(mod_en), .cpu_stall(cpu_stall), .cpu_reset(cpu_reset)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit [1:0] exp_read();
        return (m_valid && m_act == 2'd1 && m_idx == 1'b0) ? m_ctrl : 2'b00;
    endfunction

    function automatic bit [3:0] exp_en();
        return m_valid ? (4'b0001 << m_act) : 4'b0000;
    endfunction

    // Apply the requirements to a scan vector the bench built.
    function automatic void model_update(input bit [7:0] v, input int len);
        if (v[len-1]) begin
            m_valid = 1;
            m_act   = v[len-2 -: 2];
        end else if (m_valid && m_act == 2'd1 && len >= 5) begin
            if (len >= 6 && v[len-2 -: 4] == 4'hD) m_idx = v[len-6];
            if (len == 8 && v[6:3] == 4'h9 && m_idx == 1'b0) m_ctrl = v[1:0];
        end
    endfunction

    // Optional capture, then shift len bits LSB first; returns bits seen on tdo.
    task automatic shift_in(input bit [7:0] v, input int len, input bit cap, output bit [7:0] seen);
        seen = '0;
        if (cap) begin
            capture_en = 1'b1;
            @(negedge clk);
            capture_en = 1'b0;
        end
        for (int i = 0; i < len; i++) begin
            shift_en = 1'b1;
            tdi = v[i];
            #1 seen[i] = tdo;
            @(negedge clk);
        end
        shift_en = 1'b0;
    endtask

    task automatic pulse_update();
        update_en = 1'b1;
        @(negedge clk);
        update_en = 1'b0;
        #1;
    endtask

    task automatic check_outs(input string req);
        check({req, " en"}, mod_en, exp_en());
        check({req, " act"}, active_mod, m_valid ? m_act : 2'd0);
        check({req, " stall"}, cpu_stall, m_ctrl[0]);
        check({req, " reset"}, cpu_reset, m_ctrl[1]);
    endtask

    // Full command: capture, shift, check readback, update, check outputs.
    task automatic run_cmd(input bit [7:0] v, input int len, input string req);
        bit [7:0] seen;
        bit [7:0] mask;
        bit [7:0] capw;
        capw = {6'b0, exp_read()};
        mask = 8'((16'h1 << len) - 1);
        shift_in(v, len, 1'b1, seen);
        check({req, " R8 readback"}, seen & mask, capw & mask);
        @(negedge clk);
        pulse_update();
        model_update(v, len);
        check_outs(req);
    endtask

    function automatic bit [7:0] v_sel(input bit [1:0] id);  return {5'b0, 1'b1, id}; endfunction
    function automatic bit [7:0] v_rsel(input bit idx);      return {2'b0, 1'b0, 4'hD, idx}; endfunction
    function automatic bit [7:0] v_wr(input bit [1:0] d);    return {1'b0, 4'h9, 1'b0, d}; endfunction
    function automatic bit [7:0] v_nop();                    return 8'h00; endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit [7:0] seen;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 en", mod_en, 4'b0);
        check("R1 act", active_mod, 2'd0);
        check("R1 stall/reset", {cpu_reset, cpu_stall}, 2'b00);
        @(negedge clk);

        // R7: write with no module selected is ignored
        run_cmd(v_wr(2'b11), 8, "R7 nosel");
        // R3 select CPU1 then write ignored (R7)
        run_cmd(v_sel(2'd2), 3, "R3 sel2");
        run_cmd(v_wr(2'b11), 8, "R7 othermod");
        // R3, R6: select CPU0 and set stall
        run_cmd(v_sel(2'd1), 3, "R3 sel1");
        run_cmd(v_wr(2'b01), 8, "R6 wr01");
        run_cmd(v_nop(), 5, "R8 nop");
        // R4: a write opcode keeps selection; R5 pointer to 1 then write ignored
        run_cmd(v_rsel(1'b1), 6, "R5 idx1");
        run_cmd(v_wr(2'b11), 8, "R7 idx1");
        run_cmd(v_nop(), 5, "R8 idx1 reads0");
        run_cmd(v_rsel(1'b0), 6, "R5 idx0");
        run_cmd(v_wr(2'b10), 8, "R6 wr10");
        run_cmd({1'b0, 4'h6, 3'b101}, 8, "R7 badop");

        // R9: capture and update in the same cycle
        shift_in(v_wr(2'b01), 8, 1'b0, seen);
        @(negedge clk);
        capture_en = 1'b1; update_en = 1'b1;
        @(negedge clk);
        capture_en = 1'b0; update_en = 1'b0;
        #1 check("R9 new ctrl", {cpu_reset, cpu_stall}, 2'b01);
        model_update(v_wr(2'b01), 8);
        shift_in(v_nop(), 5, 1'b0, seen);
        check("R9 old value captured", seen[4:0], 5'b00010);
        @(negedge clk);
        pulse_update();
        run_cmd(v_nop(), 5, "R9 later read new");

        // R9: capture wins over shift (ctrl=01 so bit1 differs from bit0)
        capture_en = 1'b1; shift_en = 1'b1; tdi = 1'b0;
        @(negedge clk);
        capture_en = 1'b0; shift_en = 1'b0;
        #1 check("R9 capture beats shift", tdo, 1'b1);
        @(negedge clk);

        // R2: shifted bits emerge on tdo after a full register length
        shift_in(8'hA5, 8, 1'b0, seen);
        shift_in(8'h07, 8, 1'b0, seen);
        check("R2 shift-through", seen, 8'hA5);
        @(negedge clk);
        pulse_update();
        model_update(8'h07, 8);
        check_outs("R4 nop-like keep");

        // Random mix against the model (R2..R8)
        for (int k = 0; k < 300; k++) begin
            int kind = $urandom_range(0, 5);
            bit [1:0] r2 = 2'($urandom);
            case (kind)
                0: run_cmd(v_sel(($urandom_range(0, 2) == 0) ? r2 : 2'd1), 3, "R3 rnd sel");
                1: run_cmd(v_rsel(($urandom_range(0, 3) == 0)), 6, "R5 rnd rsel");
                2, 3: run_cmd(v_wr(r2), 8, "R6 rnd wr");
                4: run_cmd(v_nop(), 5, "R8 rnd nop");
                default: run_cmd({1'b0, 4'($urandom_range(1, 8)), 3'($urandom)}, 8, "R4 rnd op");
            endcase
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule